// File: doc/BRIEF.md
# Command Cell Filter Receiver

This block sits on a 4-bit nibble-wide cell bus that carries fixed-size ATM cells, each announced by a one-clock frame marker. It compares every cell header against the control-cell address. Cells that do not match are forwarded unchanged, after a fixed delay, onto a downstream 4-bit cell bus. Cells that do match are command cells. They are removed from the stream. Their command, sub-command, cell number, data count and data bytes are captured into a register file, and a downstream command executor reads them from there.

The block holds the switch address. That address is taken from an input during reset, and a change-address command can replace it later. The block also holds a busy interlock. Once a command cell is accepted, busy stays high until the executor signals completion. A command cell that arrives during that time is discarded and raises a sticky overflow flag. The pass-through delay is long enough that the address decision is known before the frame marker of a cell reaches the output. A filtered cell therefore leaves no trace downstream.

Top module: `cmd_cell_filter`

## Requirements
- R1: A cell that is not a command cell appears at the output unchanged, both its frame marker and its nibbles. The output in the clock period after edge n+7 equals the input sampled at edge n (default delay of 8 stages).
- R2: A cell is a command cell when VPI is 0x00, VCI[15:8] is 0x00 and VCI[7:0] equals the switch address. After the marker, nibble 0 is GFC, nibbles 1-2 are VPI, nibbles 3-6 are VCI[15:0] (most significant nibble first), nibble 7 is PTI/CLP and nibbles 8-9 are HEC. GFC, PTI/CLP and HEC do not affect the decision.
- R3: A command cell produces no output frame marker. Its 106 nibble slots are driven as 0 on the output.
- R4: Payload byte k is carried in nibbles 10+2k (high half) and 11+2k (low half). The captured bytes, in order, are command, sub-command, cell number, data count, then data bytes 0 to 12. Data byte k appears on `dataBytes[8k+7:8k]`.
- R5: For each accepted command cell, `cmdValid` is high for exactly one clock. That clock is the one after the edge that samples nibble 105.
- R6: `busy` rises when a command cell is accepted. It falls at the first edge that samples `cmdDone` high once capture has ended. The command decode outputs are taken from the captured command byte: `ackReq` is bit 7, `statusReq` is bit 6 and `opcode` is bits 2:0. Bits 5:3 are ignored.
- R7: A command cell that arrives while busy is filtered from the stream but is not captured. It changes no captured field, raises no `cmdValid`, and sets `overflow`. `overflow` stays set until reset.
- R8: During reset, the switch address is loaded from `swAddrInit`. An accepted command with opcode 7 replaces the address with its sub-command byte at the end of that cell, so the new address applies to later cells.
- R9: Cells may follow back to back, with the next frame marker in the same clock as nibble 105 of the previous cell. Filtering and capture work as for separated cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| swAddrInit | input | 8 | Switch address loaded during reset |
| frmIn | input | 1 | Input frame marker, one clock before nibble 0 |
| nibIn | input | 4 | Input cell nibble |
| cmdDone | input | 1 | Executor has finished the current command |
| frmOut | output | 1 | Output frame marker |
| nibOut | output | 4 | Output cell nibble |
| cmdValid | output | 1 | One-clock pulse: a command has been captured |
| cmdByte | output | 8 | Captured command byte |
| subCmd | output | 8 | Captured sub-command byte |
| cellNum | output | 8 | Captured cell number |
| dataCount | output | 8 | Captured data count |
| dataBytes | output | 104 | Captured data bytes, byte 0 in the low bits |
| ackReq | output | 1 | Acknowledge cell requested |
| statusReq | output | 1 | Status check requested before read or write |
| opcode | output | 3 | Command opcode |
| busy | output | 1 | A command is being captured or executed |
| overflow | output | 1 | Sticky: a command cell was discarded while busy |
| swAddr | output | 8 | Current switch address |

## Verification
The assertions rely on two properties of the input. Frame markers are at least 106 clocks apart, so a marker never interrupts a cell. `cmdDone` is raised only between cells, after a command has been presented. The stimulus keeps to both: cells are always sent complete, either back to back or with idle gaps, and completion is signalled only in idle cycles. A bench reference model predicts every output nibble, every frame marker and every `cmdValid` clock. It also tracks busy, overflow and the address across accepted, discarded and address-changing commands.

// File: rtl/cellf_pkg.sv
package cellf_pkg;
  localparam int NIB_W     = 4;
  localparam int CELL_LAST = 105;
  localparam int HDR_LAST  = 6;
  localparam int PAY_FIRST = 10;
  localparam int IDX_W     = 5;

  typedef struct packed {
    logic             capHi;
    logic             capLo;
    logic [IDX_W-1:0] byteIdx;
    logic             cellDrop;
  } ctlStrobe_t;
endpackage

// File: rtl/cellf_ctrl.sv
module cellf_ctrl
  import cellf_pkg::*;
#(
  parameter int NUM_REGS = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmIn,
  input  logic [NIB_W-1:0] nibIn,
  input  logic [7:0]       swAddrInit,
  input  logic             cmdDone,
  input  logic [2:0]       opcode,
  input  logic [7:0]       subByte,
  output ctlStrobe_t       strobe,
  output logic             busy,
  output logic             overflow,
  output logic             cmdValid,
  output logic [7:0]       swAddr
);
  localparam int CAP_LAST = PAY_FIRST + 2 * NUM_REGS - 1;
  localparam logic [2:0] OP_SETADDR = 3'd7;

  logic       active;
  logic [6:0] pos;
  logic       matchR, dropR, capturing;
  logic       hdrEnd, hit, acceptNow, cellEnd, capWin;
  logic [6:0] payOfs;

  always_comb begin
    hdrEnd    = active && (pos == 7'(HDR_LAST));
    hit       = hdrEnd && matchR && (nibIn == swAddr[3:0]);
    acceptNow = hit && !busy;
    cellEnd   = active && (pos == 7'(CELL_LAST));
    capWin    = capturing && active && (pos >= 7'(PAY_FIRST)) && (pos <= 7'(CAP_LAST));
    payOfs    = pos - 7'(PAY_FIRST);
    strobe.capHi    = capWin && !pos[0];
    strobe.capLo    = capWin && pos[0];
    strobe.byteIdx  = payOfs[IDX_W:1];
    strobe.cellDrop = dropR;
  end

  // nibble position tracker
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (frmIn) begin
      active <= 1'b1;
      pos    <= '0;
    end else if (active) begin
      if (pos == 7'(CELL_LAST)) active <= 1'b0;
      else pos <= pos + 7'd1;
    end
  end

  // header address match
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchR <= 1'b0;
      dropR  <= 1'b0;
    end else if (active) begin
      if (pos == 7'd0) matchR <= 1'b1;
      else if (pos <= 7'd4) matchR <= matchR && (nibIn == 4'd0);
      else if (pos == 7'd5) matchR <= matchR && (nibIn == swAddr[7:4]);
      if (hdrEnd) dropR <= hit;
    end
  end

  // command acceptance, interlock and address ownership
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capturing <= 1'b0;
      busy      <= 1'b0;
      overflow  <= 1'b0;
      cmdValid  <= 1'b0;
      swAddr    <= swAddrInit;
    end else begin
      cmdValid <= 1'b0;
      if (acceptNow) capturing <= 1'b1;
      else if (capturing && cellEnd) begin
        capturing <= 1'b0;
        cmdValid  <= 1'b1;
        if (opcode == OP_SETADDR) swAddr <= subByte;
      end
      if (acceptNow) busy <= 1'b1;
      else if (cmdDone && !capturing) busy <= 1'b0;
      if (hit && busy) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/cellf_dpath.sv
module cellf_dpath
  import cellf_pkg::*;
#(
  parameter int PASS_DELAY = 8,
  parameter int NUM_REGS   = 17
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frmIn,
  input  logic [NIB_W-1:0]      nibIn,
  input  ctlStrobe_t            strobe,
  output logic                  frmOut,
  output logic [NIB_W-1:0]      nibOut,
  output logic [NUM_REGS*8-1:0] regsFlat
);
  localparam int SLOT_W = NIB_W + 1;
  localparam int LINE_W = PASS_DELAY * SLOT_W;

  logic [LINE_W-1:0] line;
  logic [SLOT_W-1:0] tailSlot;
  logic              outDrop;
  logic [NIB_W-1:0]  hiNib;

  always_ff @(posedge clk) begin
    if (!rstN) line <= '0;
    else line <= {line[LINE_W-SLOT_W-1:0], frmIn, nibIn};
  end

  assign tailSlot = line[LINE_W-1 -: SLOT_W];

  // drop decision latched as the filtered cell's marker leaves the line
  always_ff @(posedge clk) begin
    if (!rstN) outDrop <= 1'b0;
    else if (tailSlot[NIB_W]) outDrop <= strobe.cellDrop;
  end

  assign frmOut = tailSlot[NIB_W] && !strobe.cellDrop;
  assign nibOut = outDrop ? '0 : tailSlot[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) hiNib <= '0;
    else if (strobe.capHi) hiNib <= nibIn;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] val;
    always_ff @(posedge clk) begin
      if (!rstN) val <= '0;
      else if (strobe.capLo && (strobe.byteIdx == IDX_W'(g))) val <= {hiNib, nibIn};
    end
    assign regsFlat[g*8 +: 8] = val;
  end
endmodule

// File: rtl/cmd_cell_filter.sv
module cmd_cell_filter
  import cellf_pkg::*;
#(
  parameter int PASS_DELAY = 8,
  parameter int NUM_DATA   = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            swAddrInit,
  input  logic                  frmIn,
  input  logic [NIB_W-1:0]      nibIn,
  input  logic                  cmdDone,
  output logic                  frmOut,
  output logic [NIB_W-1:0]      nibOut,
  output logic                  cmdValid,
  output logic [7:0]            cmdByte,
  output logic [7:0]            subCmd,
  output logic [7:0]            cellNum,
  output logic [7:0]            dataCount,
  output logic [NUM_DATA*8-1:0] dataBytes,
  output logic                  ackReq,
  output logic                  statusReq,
  output logic [2:0]            opcode,
  output logic                  busy,
  output logic                  overflow,
  output logic [7:0]            swAddr
);
  localparam int NUM_REGS = NUM_DATA + 4;

  ctlStrobe_t            strobe;
  logic [NUM_REGS*8-1:0] regsFlat;

  cellf_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frmIn(frmIn), .nibIn(nibIn),
    .swAddrInit(swAddrInit), .cmdDone(cmdDone), .opcode(opcode),
    .subByte(subCmd), .strobe(strobe), .busy(busy), .overflow(overflow),
    .cmdValid(cmdValid), .swAddr(swAddr)
  );

  cellf_dpath #(.PASS_DELAY(PASS_DELAY), .NUM_REGS(NUM_REGS)) u_dpath (
    .clk(clk), .rstN(rstN), .frmIn(frmIn), .nibIn(nibIn), .strobe(strobe),
    .frmOut(frmOut), .nibOut(nibOut), .regsFlat(regsFlat)
  );

  assign cmdByte   = regsFlat[7:0];
  assign subCmd    = regsFlat[15:8];
  assign cellNum   = regsFlat[23:16];
  assign dataCount = regsFlat[31:24];
  assign dataBytes = regsFlat[NUM_REGS*8-1:32];
  assign ackReq    = cmdByte[7];
  assign statusReq = cmdByte[6];
  assign opcode    = cmdByte[2:0];
endmodule

// File: rtl/cmd_cell_filter_sva.sv
module cmd_cell_filter_sva (
  input logic       clk,
  input logic       rstN,
  input logic       frmOut,
  input logic       cmdValid,
  input logic       cmdDone,
  input logic       busy,
  input logic       overflow,
  input logic [7:0] swAddr
);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdDone) |=> busy);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_addr_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swAddr) |-> cmdValid);

  assert_frm_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    frmOut |=> !frmOut);
endmodule

bind cmd_cell_filter cmd_cell_filter_sva u_sva (.*);

// File: tb/cmd_cell_filter_bench.sv
module cmd_cell_filter_bench;
  localparam int DLY  = 8;
  localparam int NREG = 17;
  localparam int HN   = 8192;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   swAddrInit = 8'h5A;
  logic         frmIn = 1'b0;
  logic [3:0]   nibIn = 4'd0;
  logic         cmdDone = 1'b0;
  logic         frmOut, cmdValid, ackReq, statusReq, busy, overflow;
  logic [3:0]   nibOut;
  logic [7:0]   cmdByte, subCmd, cellNum, dataCount, swAddr;
  logic [103:0] dataBytes;
  logic [2:0]   opcode;

  cmd_cell_filter #(.PASS_DELAY(DLY), .NUM_DATA(13)) u_cmd_cell_filter (
    .clk(clk), .rstN(rstN), .swAddrInit(swAddrInit), .frmIn(frmIn), .nibIn(nibIn),
    .cmdDone(cmdDone), .frmOut(frmOut), .nibOut(nibOut), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .subCmd(subCmd), .cellNum(cellNum), .dataCount(dataCount),
    .dataBytes(dataBytes), .ackReq(ackReq), .statusReq(statusReq), .opcode(opcode),
    .busy(busy), .overflow(overflow), .swAddr(swAddr)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit       frm;
    bit [3:0] nib;
    bit       done;
    bit       frmDrop;
    bit       nibDrop;
    bit       vld;
  } ent_t;

  ent_t q[$];
  bit       hFrm[HN], hFrmDrop[HN], hNibDrop[HN], hVld[HN];
  bit [3:0] hNib[HN];
  int cyc = 0;
  int nChecks = 0;
  int nErrors = 0;
  bit monEn = 0;
  bit finished = 0;

  bit [7:0] mAddr = 8'h5A;
  bit       mBusy = 0;
  bit       mOvf = 0;
  bit [7:0] mRegs[NREG];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference history
  always @(negedge clk) begin
    if (monEn && cyc >= DLY && cyc < HN) begin
      int s;
      bit eFrm;
      bit [3:0] eNib;
      s = cyc - (DLY - 1);
      eFrm = hFrm[s] && !hFrmDrop[s];
      eNib = hNibDrop[s] ? 4'd0 : hNib[s];
      chk(frmOut == eFrm, hFrmDrop[s] ? "R3 frame marker" : "R1 frame marker", frmOut, eFrm);
      chk(nibOut == eNib, hNibDrop[s] ? "R3 nibble" : "R1 nibble", nibOut, eNib);
      chk(cmdValid == hVld[cyc], "R5 cmdValid", cmdValid, hVld[cyc]);
    end
  end

  task automatic pushIdle(input int n, input bit done);
    for (int i = 0; i < n; i++) begin
      ent_t e;
      e = '{frm: 0, nib: 4'd0, done: done, frmDrop: 0, nibDrop: 0, vld: 0};
      q.push_back(e);
    end
    if (done) mBusy = 0;
  endtask

  task automatic pushCell(input bit [3:0] gfc, input bit [7:0] vpi, input bit [15:0] vci,
                          input bit [3:0] pti, input bit [7:0] hec, input bit [7:0] cmd,
                          input bit [7:0] sub, input bit [7:0] num, input bit [7:0] cnt,
                          input bit [7:0] seed, input bit b2b);
    bit [3:0] n[106];
    bit [7:0] pb[48];
    bit hit, acc;
    ent_t e;
    for (int k = 0; k < 48; k++) pb[k] = seed + 8'(k * 13);
    pb[0] = cmd; pb[1] = sub; pb[2] = num; pb[3] = cnt;
    n[0] = gfc; n[1] = vpi[7:4]; n[2] = vpi[3:0];
    n[3] = vci[15:12]; n[4] = vci[11:8]; n[5] = vci[7:4]; n[6] = vci[3:0];
    n[7] = pti; n[8] = hec[7:4]; n[9] = hec[3:0];
    for (int k = 0; k < 48; k++) begin
      n[10 + 2*k] = pb[k][7:4];
      n[11 + 2*k] = pb[k][3:0];
    end
    hit = (vpi == 8'h00) && (vci[15:8] == 8'h00) && (vci[7:0] == mAddr);
    acc = hit && !mBusy;
    if (hit && mBusy) mOvf = 1;
    if (b2b && q.size() > 0) begin
      e = q.pop_back();
      e.frm = 1; e.frmDrop = hit;
      q.push_back(e);
    end else begin
      e = '{frm: 1, nib: 4'd0, done: 0, frmDrop: hit, nibDrop: 0, vld: 0};
      q.push_back(e);
    end
    for (int i = 0; i < 106; i++) begin
      e = '{frm: 0, nib: n[i], done: 0, frmDrop: 0, nibDrop: hit, vld: acc && (i == 105)};
      q.push_back(e);
    end
    if (acc) begin
      mBusy = 1;
      for (int k = 0; k < NREG; k++) mRegs[k] = pb[k];
      if (cmd[2:0] == 3'd7) mAddr = sub;
    end
  endtask

  task automatic flush();
    pushIdle(12, 0);
    while (q.size() > 0) begin
      ent_t e;
      e = q.pop_front();
      frmIn = e.frm; nibIn = e.nib; cmdDone = e.done;
      if (cyc + 1 < HN) begin
        hFrm[cyc+1] = e.frm; hNib[cyc+1] = e.nib; hFrmDrop[cyc+1] = e.frmDrop;
        hNibDrop[cyc+1] = e.nibDrop; hVld[cyc+1] = e.vld;
      end
      @(negedge clk);
    end
    frmIn = 0; nibIn = 0; cmdDone = 0;
  endtask

  task automatic checkState(input string tag);
    chk(busy == mBusy, {tag, " busy"}, busy, mBusy);
    chk(overflow == mOvf, {tag, " overflow"}, overflow, mOvf);
    chk(swAddr == mAddr, {tag, " swAddr"}, swAddr, mAddr);
    chk(cmdByte == mRegs[0], {tag, " cmdByte"}, cmdByte, mRegs[0]);
    chk(subCmd == mRegs[1], {tag, " subCmd"}, subCmd, mRegs[1]);
    chk(cellNum == mRegs[2], {tag, " cellNum"}, cellNum, mRegs[2]);
    chk(dataCount == mRegs[3], {tag, " dataCount"}, dataCount, mRegs[3]);
    for (int k = 0; k < 13; k++)
      chk(dataBytes[k*8 +: 8] == mRegs[4+k], {tag, " dataBytes"}, dataBytes[k*8 +: 8], mRegs[4+k]);
    chk(ackReq == mRegs[0][7], {tag, " ackReq"}, ackReq, mRegs[0][7]);
    chk(statusReq == mRegs[0][6], {tag, " statusReq"}, statusReq, mRegs[0][6]);
    chk(opcode == mRegs[0][2:0], {tag, " opcode"}, opcode, mRegs[0][2:0]);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    monEn = 1;
    @(negedge clk);
    // reset state: R8 address load, R6 idle interlock
    chk(frmOut == 0, "R1 reset frmOut", frmOut, 0);
    chk(cmdValid == 0, "R5 reset cmdValid", cmdValid, 0);
    checkState("R8 reset");

    // R2: near-miss headers pass through
    pushIdle(3, 0);
    pushCell(4'h0, 8'h01, 16'h005A, 4'h0, 8'h00, 8'h02, 8'h00, 8'h01, 8'h01, 8'h10, 0);
    pushCell(4'h0, 8'h00, 16'h015A, 4'h0, 8'h00, 8'h02, 8'h00, 8'h02, 8'h01, 8'h20, 0);
    pushCell(4'h0, 8'h00, 16'h005B, 4'h0, 8'h00, 8'h02, 8'h00, 8'h03, 8'h01, 8'h30, 0);
    flush();
    checkState("R2 near-miss");

    // R2 R4 R6: command with noisy GFC/PTI/HEC captured
    pushCell(4'hF, 8'h00, 16'h005A, 4'hF, 8'hAB, 8'hC2, 8'h11, 8'h21, 8'h0D, 8'h40, 0);
    flush();
    checkState("R4 capture");

    // R7: command while busy is dropped and flagged
    pushCell(4'h0, 8'h00, 16'h005A, 4'h0, 8'h00, 8'h01, 8'h22, 8'h22, 8'h02, 8'h77, 0);
    flush();
    checkState("R7 busy drop");

    // R6: completion releases the interlock
    pushIdle(1, 1);
    flush();
    checkState("R6 done");

    // R8: change address to 0x33
    pushCell(4'h0, 8'h00, 16'h005A, 4'h0, 8'h00, 8'h87, 8'h33, 8'h05, 8'h00, 8'h50, 0);
    flush();
    checkState("R8 change addr");
    pushIdle(1, 1);
    flush();

    // R9: back-to-back: old address passes, new address captured, then pass-through
    pushCell(4'h0, 8'h00, 16'h005A, 4'h0, 8'h00, 8'h02, 8'h00, 8'h06, 8'h01, 8'h60, 0);
    pushCell(4'h3, 8'h00, 16'h0033, 4'h5, 8'h99, 8'h39, 8'h44, 8'h07, 8'h05, 8'h70, 1);
    pushCell(4'h0, 8'h02, 16'h0033, 4'h0, 8'h00, 8'h02, 8'h00, 8'h08, 8'h01, 8'h80, 1);
    flush();
    checkState("R9 back-to-back R6 decode");
    pushIdle(1, 1);
    flush();
    checkState("R6 final");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule